// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock waveform of an I2C controller together with the two instants inside each clock cycle that the data path needs. The input clock is divided into a time quantum of `pre_div+1` cycles. Every other interval is counted in that quantum. The intervals are the SCL low length, the SCL high length, the delay after SCL falls before SDA may take new data, and the setup time that new data needs before SCL may rise. The block drives SCL only through an open-drain enable.

Each low phase starts by loading all timing fields. The `sda_chg` strobe then marks the cycle in which SDA may change. The low phase ends once two conditions hold: the low length has elapsed, and the setup time measured from the SDA change has elapsed. The `scl_rel` strobe marks the final cycle of the low phase.

Once SCL is released, the block waits until it sees the wire high before it starts counting the high phase. A target that stretches the clock therefore lengthens the cycle instead of shortening it. Stretch support can be turned off. Dropping the enable releases SCL and clears all counting state.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en` is low no strobe is raised, and `scl_oe` is 0 from the cycle after `en` is seen low. This includes reset.
- R2: One cycle after `en` is first seen high, `scl_oe` becomes 1, which begins a low phase.
- R3: A quantum lasts `pre_div+1` clock cycles. `scl_oe` stays 1 for `max(lo_len+1, hold_len+setup_len+1)` quanta.
- R4: `sda_chg` is a single-cycle pulse, given once per low phase, `hold_len*(pre_div+1)` cycles after `scl_oe` rises. With `hold_len` = 0 it falls in the first low cycle.
- R5: When `hold_len+setup_len+1` exceeds `lo_len+1`, the low phase is lengthened so that SCL rises no earlier than `setup_len+1` quanta after the SDA change.
- R6: `scl_rel` pulses in the last cycle in which `scl_oe` is 1.
- R7: With nothing holding the line, `scl_oe` stays 0 for `1+(hi_len+1)*(pre_div+1)` cycles. This is one sampling cycle followed by the high count.
- R8: With `stretch_en`=1, the high count starts only in the cycle after `scl_in` is seen high. Each extra cycle the line is held low adds one cycle to the released time.
- R9: With `stretch_en`=0, the high count starts one cycle after release whatever `scl_in` shows.
- R10: All timing fields are loaded at the start of each low phase. A change made during a bit takes effect from the next bit.
- R11: `sda_chg` and `scl_rel` may assert in the same cycle, when the SDA change falls in the last low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| stretch_en | input | 1 | Wait for SCL high before counting the high phase |
| pre_div | input | 4 | Quantum is pre_div+1 clock cycles |
| lo_len | input | 8 | Low length minus one, in quanta |
| hi_len | input | 8 | High length minus one, in quanta |
| hold_len | input | 4 | SDA hold after SCL falls, in quanta |
| setup_len | input | 4 | SDA setup before SCL rises, minus one, in quanta |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_chg | output | 1 | Strobe: SDA may change now |
| scl_rel | output | 1 | Strobe: final cycle of the low phase |

## Verification
The two strobes can coincide. The data-change point and the release point fall in one cycle when `pre_div` is 0, `setup_len` is 0 and `hold_len` is at least `lo_len`, because the SDA change then lands in the last low cycle. The bench runs this setting and measures both strobe positions from the `scl_oe` rising edge. It expects each at the final low cycle of the same bit, and it expects exactly one data-change pulse in that phase. Stretching with the feature off, and field writes made in the middle of a bit, are judged the same way against the per-bit lengths the bench predicts.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int PW = 4,
  parameter int TW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stretch_en,
  input  logic [PW-1:0] pre_div,
  input  logic [TW-1:0] lo_len,
  input  logic [TW-1:0] hi_len,
  input  logic [DW-1:0] hold_len,
  input  logic [DW-1:0] setup_len,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          sda_chg,
  output logic          scl_rel
);
  localparam int CW = ((TW > DW) ? TW : DW) + 2;

  typedef enum logic [1:0] {S_OFF, S_LOW, S_WAIT, S_HIGH} st_t;
  st_t st;

  logic [PW-1:0] pcnt, pre_l;
  logic [CW-1:0] q;
  logic [TW-1:0] lo_l, hi_l;
  logic [DW-1:0] hold_l, setup_l;

  logic [CW-1:0] lo_end, su_end, lim;
  logic tick, last_lo, last_hi, load;

  assign lo_end  = CW'(lo_l) + CW'(1);
  assign su_end  = CW'(hold_l) + CW'(setup_l) + CW'(1);
  assign lim     = (lo_end > su_end) ? lo_end : su_end;
  assign tick    = (pcnt == pre_l);
  assign last_lo = tick && (q + CW'(1) == lim);
  assign last_hi = tick && (q == CW'(hi_l));
  assign load    = en && ((st == S_OFF) || (st == S_HIGH && last_hi));

  assign sda_chg = en && (st == S_LOW) && (pcnt == '0) && (q == CW'(hold_l));
  assign scl_rel = en && (st == S_LOW) && last_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_l <= '0; lo_l <= '0; hi_l <= '0; hold_l <= '0; setup_l <= '0;
    end else if (load) begin
      pre_l <= pre_div; lo_l <= lo_len; hi_l <= hi_len;
      hold_l <= hold_len; setup_l <= setup_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; pcnt <= '0; q <= '0; scl_oe <= 1'b0;
    end else if (!en) begin
      st <= S_OFF; pcnt <= '0; q <= '0; scl_oe <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          st <= S_LOW; pcnt <= '0; q <= '0; scl_oe <= 1'b1;
        end
        S_LOW: begin
          if (!tick) pcnt <= pcnt + PW'(1);
          else begin
            pcnt <= '0;
            if (last_lo) begin
              st <= S_WAIT; q <= '0; scl_oe <= 1'b0;
            end else q <= q + CW'(1);
          end
        end
        S_WAIT: begin
          if (scl_in || !stretch_en) st <= S_HIGH;
        end
        S_HIGH: begin
          if (!tick) pcnt <= pcnt + PW'(1);
          else begin
            pcnt <= '0;
            if (last_hi) begin
              st <= S_LOW; q <= '0; scl_oe <= 1'b1;
            end else q <= q + CW'(1);
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assert_off_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_oe);
  assert_start_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_OFF) |=> scl_oe);
  assert_quantum_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= pre_l);
  assert_sda_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |-> scl_oe);
  assert_sda_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |=> !sda_chg);
  assert_rel_then_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rel |=> !scl_oe);
  assert_stretch_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_WAIT && stretch_en && !scl_in) |=> (st == S_WAIT && !scl_oe));
  assert_no_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_WAIT && !stretch_en) |=> (st == S_HIGH));
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, stretch_en = 1'b1;
  logic [3:0] pre_div = '0, hold_len = '0, setup_len = '0;
  logic [7:0] lo_len = '0, hi_len = '0;
  logic hold_line = 1'b0;
  logic scl_in, scl_oe, sda_chg, scl_rel;

  assign scl_in = ~scl_oe & ~hold_line;
  always #(CLK_NS/2) clk = ~clk;

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .stretch_en(stretch_en),
    .pre_div(pre_div), .lo_len(lo_len), .hi_len(hi_len),
    .hold_len(hold_len), .setup_len(setup_len),
    .scl_in(scl_in), .scl_oe(scl_oe), .sda_chg(sda_chg), .scl_rel(scl_rel));

  typedef struct { int lo; int sd; int hi; string rq; } exp_t;
  exp_t sb[$];
  exp_t cur;

  int checks = 0, fails = 0, str_len = 0, scnt = 0;
  int cyc = 0, rise_t = 0, fall_t = 0, sda_t = 0, sda_n = 0, rel_t = -1;
  bit mon_on = 1'b0, have_rise = 1'b0, have_cur = 1'b0, prev = 1'b0;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic set_push(int p, int l, int h, int hd, int su, int n, int s, bit se, string rq);
    int lim;
    wait (hold_line == 1'b0);
    pre_div = 4'(p); lo_len = 8'(l); hi_len = 8'(h);
    hold_len = 4'(hd); setup_len = 4'(su);
    str_len = s; stretch_en = se;
    lim = (l + 1 > hd + su + 1) ? l + 1 : hd + su + 1;
    for (int i = 0; i < n; i++)
      sb.push_back('{lim * (p + 1), hd * (p + 1),
                     1 + (se ? s : 0) + (h + 1) * (p + 1), rq});
  endtask

  task automatic drain();
    wait (sb.size() == 0);
  endtask

  always @(negedge clk) begin
    if (scl_rel && str_len > 0) begin
      hold_line <= 1'b1; scnt <= str_len + 1;
    end else if (scnt > 0) begin
      if (scnt == 1) hold_line <= 1'b0;
      scnt <= scnt - 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!mon_on) begin
      have_rise = 0; have_cur = 0; sda_n = 0; rel_t = -1;
    end else begin
      if (scl_oe && !prev) begin
        if (have_cur) begin
          chk(cyc - fall_t == cur.hi, {cur.rq, " high length"}, cyc - fall_t, cur.hi);
          have_cur = 0;
        end
        rise_t = cyc; have_rise = 1; sda_n = 0; rel_t = -1;
      end
      if (scl_oe && sda_chg) begin sda_n++; sda_t = cyc; end
      if (scl_rel) rel_t = cyc;
      if (!scl_oe && prev && have_rise) begin
        if (sb.size() == 0) chk(0, "scoreboard underflow", 0, 1);
        else begin
          cur = sb.pop_front(); have_cur = 1;
          chk(cyc - rise_t == cur.lo, {cur.rq, " R3 R5 low length"}, cyc - rise_t, cur.lo);
          chk(sda_n == 1 && sda_t - rise_t == cur.sd, {cur.rq, " R4 sda change offset"},
              (sda_n == 1) ? sda_t - rise_t : -sda_n, cur.sd);
          chk(rel_t == cyc - 1, {cur.rq, " R6 release strobe"}, rel_t - rise_t, cyc - 1 - rise_t);
        end
        fall_t = cyc;
      end
    end
    prev = scl_oe;
  end

  initial begin
    #(CLK_NS * 200000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_chg && !scl_rel, "R1 reset state", scl_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_oe, "R1 idle while disabled", scl_oe, 0);

    mon_on = 1'b1;
    set_push(1, 9, 3, 3, 3, 3, 0, 1'b1, "R3 R7 fast");
    en = 1'b1;
    @(negedge clk);
    chk(scl_oe, "R2 drive after enable", scl_oe, 1);
    drain();
    set_push(3, 19, 15, 2, 4, 2, 0, 1'b1, "R3 R7 standard");
    drain();
    set_push(1, 1, 2, 2, 3, 2, 0, 1'b1, "R5 setup extends low");
    drain();
    set_push(0, 2, 1, 3, 0, 2, 0, 1'b1, "R11 coinciding strobes");
    drain();
    set_push(2, 4, 0, 0, 1, 2, 0, 1'b1, "R4 zero hold");
    drain();
    set_push(1, 3, 2, 1, 1, 2, 5, 1'b1, "R8 stretched");
    drain();
    set_push(1, 3, 2, 1, 1, 1, 0, 1'b1, "R8 after stretch");
    drain();
    set_push(1, 3, 2, 1, 1, 2, 4, 1'b0, "R9 stretch ignored");
    drain();

    set_push(1, 6, 2, 2, 1, 1, 0, 1'b1, "R10 old fields");
    do @(negedge clk); while (!scl_oe);
    repeat (2) @(negedge clk);
    set_push(0, 2, 4, 1, 0, 2, 0, 1'b1, "R10 new fields");
    drain();
    wait (!have_cur);
    mon_on = 1'b0;

    do @(negedge clk); while (!scl_oe);
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_oe, "R1 release on disable", scl_oe, 0);
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (scl_oe || sda_chg || scl_rel) bad++;
    end
    chk(bad == 0, "R1 quiet while disabled", bad, 0);

    mon_on = 1'b1;
    set_push(2, 3, 1, 1, 2, 2, 0, 1'b1, "R2 R3 re-enabled");
    en = 1'b1;
    drain();
    wait (!have_cur);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule